// File: doc/BRIEF.md
# Timer Clock Prescaler and Source Selector

This block decides, cycle by cycle, whether an 8-bit timer/counter should advance. It owns one 8-bit control register with a halt-mode flag, a self-clearing divider-restart flag and a 3-bit source field. From that field it drives a single-cycle strobe, `count_en`, which comes from one of several sources:
- nothing;
- every system clock;
- one of four taps of a free-running 10-bit divider;
- a synchronized edge of an external pin.

The timer counter, its compare logic and its interrupts sit outside the block.

Software writes the register through a plain write strobe and reads it back over a combinational read bus. Setting the halt-mode flag together with the restart flag keeps the divider cleared and suppresses all strobes, so the timer can be configured without advancing. Clearing the halt-mode flag drops the restart flag and counting resumes from a freshly cleared divider.

The block has no streaming data path, so no interface uses valid/ready. The register port takes a write on every cycle that `reg_wr` is high and never applies back-pressure. The strobe output is a plain level, sampled by the timer on each rising clock edge.

Top module: `tpre_timer_prescaler`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00 and `count_en` is low.
- R2: Register bit 4 is the halt-mode flag, bit 3 is the divider-restart flag and bits 2..0 are the source field. Bits 7..5 always read zero, and writing ones to them has no effect.
- R3: With the halt-mode flag clear, a written restart flag reads as one for exactly one cycle and then reads zero without any further write.
- R4: With the halt-mode flag set, a written restart flag stays set until the next write. While the restart flag is set, `count_en` stays low for every source.
- R5: A write that clears both flags releases the divider. Call the cycle in which that write is latched cycle 0. The first strobe of a divide-by-N source comes in cycle N-1, and further strobes come every N cycles.
- R6: Source 000 never strobes. Source 001 strobes in every cycle in which the restart flag is clear.
- R7: Sources 010, 011, 100 and 101 strobe once every 8, 64, 256 and 1024 clocks. A strobe comes when the matching low bits of the divider are all ones.
- R8: Sources 110 and 111 strobe once for each falling or rising edge of `ext_pin`, with no division. The pin passes through two synchronizer flops, so the strobe comes in the second clock after the first rising clock edge that samples the new pin level. Edges of the other polarity produce no strobe.
- R9: A write that changes the source field without setting the restart flag takes effect on the next cycle and does not clear the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data for the control register |
| reg_rdata | output | 8 | Current control register value |
| ext_pin | input | 1 | Asynchronous external count source |
| count_en | output | 1 | Single-cycle advance strobe for the timer |

## Verification
The assertions check these properties on every cycle:
- the restart flag clears itself, or stays set in halt mode;
- no strobe appears while the divider is held;
- source 000 stays silent and source 001 strobes in every free cycle;
- each coarser divider tap fires only together with the finer taps;
- synchronized edge pulses last one cycle and rise and fall pulses never coincide.

Only the bench scenarios can show the exact phase of the first divided strobe after a release, the periods of all four taps, the two-flop latency of the pin path, and that a change of source leaves the divider phase untouched.

// File: rtl/tpre_pkg.sv
package tpre_pkg;
  localparam int REG_W     = 8;
  localparam int CS_W      = 3;
  localparam int BIT_HALT  = 4;
  localparam int BIT_RST   = 3;
  localparam int NUM_TAPS  = 4;

  typedef enum logic [CS_W-1:0] {
    SRC_OFF      = 3'd0,
    SRC_SYS      = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV64    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_PIN_FALL = 3'd6,
    SRC_PIN_RISE = 3'd7
  } src_sel_e;

  typedef struct packed {
    logic     halt_mode;
    logic     div_restart;
    src_sel_e src;
  } ctrl_t;
endpackage

// File: rtl/tpre_ctrl_reg.sv
module tpre_ctrl_reg
  import tpre_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output ctrl_t            ctrl
);
  ctrl_t ctrl_q;
  logic  unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:BIT_HALT+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.halt_mode   <= wr_data[BIT_HALT];
      ctrl_q.div_restart <= wr_data[BIT_RST];
      ctrl_q.src         <= src_sel_e'(wr_data[CS_W-1:0]);
    end else if (!ctrl_q.halt_mode) begin
      ctrl_q.div_restart <= 1'b0;
    end
  end

  always_comb begin
    rd_data              = '0;
    rd_data[BIT_HALT]    = ctrl_q.halt_mode;
    rd_data[BIT_RST]     = ctrl_q.div_restart;
    rd_data[CS_W-1:0]    = ctrl_q.src;
  end

  assign ctrl = ctrl_q;

  // R3: restart flag lasts one cycle outside halt mode
  p_restart_selfclear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.div_restart && !ctrl_q.halt_mode && !wr_en) |=> !ctrl_q.div_restart);

  // R4: restart flag held in halt mode until a write
  p_restart_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.div_restart && ctrl_q.halt_mode && !wr_en) |=> ctrl_q.div_restart);
endmodule

// File: rtl/tpre_divider.sv
module tpre_divider #(
  parameter int CNT_W = 10,
  parameter int TAP0  = 3,
  parameter int TAP1  = 6,
  parameter int TAP2  = 8,
  parameter int TAP3  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  output logic [3:0] tap_stb
);
  localparam int N_TAPS = 4;

  function automatic int tap_bits(input int idx);
    case (idx)
      0:       return TAP0;
      1:       return TAP1;
      2:       return TAP2;
      default: return TAP3;
    endcase
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    localparam int TB = tap_bits(g);
    assign tap_stb[g] = !clr && (&cnt_q[TB-1:0]);
    if (g > 0) begin : g_nest
      // R7: a coarser tap only fires together with the finer one
      p_tap_nested_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tap_stb[g] |-> tap_stb[g-1]);
    end
  end
endmodule

// File: rtl/tpre_pin_sync.sv
module tpre_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise_stb,
  output logic fall_stb
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_stb = sync_q[STAGES-1] && !last_q;
  assign fall_stb = !sync_q[STAGES-1] && last_q;

  // R8: one strobe per edge
  p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> !rise_stb);
  p_fall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb);
  p_edges_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));
endmodule

// File: rtl/tpre_src_mux.sv
module tpre_src_mux
  import tpre_pkg::*;
(
  input  src_sel_e      src,
  input  logic          hold,
  input  logic [NUM_TAPS-1:0] tap_stb,
  input  logic          rise_stb,
  input  logic          fall_stb,
  output logic          strobe
);
  always_comb begin
    strobe = 1'b0;
    case (src)
      SRC_OFF:      strobe = 1'b0;
      SRC_SYS:      strobe = 1'b1;
      SRC_DIV8:     strobe = tap_stb[0];
      SRC_DIV64:    strobe = tap_stb[1];
      SRC_DIV256:   strobe = tap_stb[2];
      SRC_DIV1024:  strobe = tap_stb[3];
      SRC_PIN_FALL: strobe = fall_stb;
      SRC_PIN_RISE: strobe = rise_stb;
      default:      strobe = 1'b0;
    endcase
    if (hold) strobe = 1'b0;
  end
endmodule

// File: rtl/tpre_timer_prescaler.sv
module tpre_timer_prescaler
  import tpre_pkg::*;
#(
  parameter int DIV_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ext_pin,
  output logic       count_en
);
  ctrl_t               ctrl;
  logic [NUM_TAPS-1:0] tap_stb;
  logic                rise_stb;
  logic                fall_stb;

  tpre_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_data (reg_wdata),
    .rd_data (reg_rdata),
    .ctrl    (ctrl)
  );

  tpre_divider #(.CNT_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctrl.div_restart),
    .tap_stb (tap_stb)
  );

  tpre_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (ext_pin),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  tpre_src_mux u_mux (
    .src      (ctrl.src),
    .hold     (ctrl.div_restart),
    .tap_stb  (tap_stb),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .strobe   (count_en)
  );

  // R4: no strobe while the divider is held
  p_halt_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[BIT_RST] |-> !count_en);
  // R6: source off is silent
  p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[CS_W-1:0] == SRC_OFF) |-> !count_en);
  // R6: system clock source strobes every free cycle
  p_sys_every_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[CS_W-1:0] == SRC_SYS && !reg_rdata[BIT_RST]) |-> count_en);
  // R2: reserved bits read zero
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr) |-> (reg_rdata[7:5] == 3'b000));
endmodule

// File: tb/tpre_timer_prescaler_bench.sv
`timescale 1ns/1ps
module tpre_timer_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ext_pin = 1'b0;
  logic       count_en;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  tpre_timer_prescaler u_tpre_timer_prescaler (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ext_pin   (ext_pin),
    .count_en  (count_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, latched by the following posedge, returns at next negedge
  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // samples from the current negedge: index 0 is now, phase0 is divider count now
  task automatic run_div(input string req, input int n, input int phase0, input int cycles);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      logic e = (((phase0 + i) % n) == n - 1);
      if (count_en !== e) bad++;
      @(negedge clk);
    end
    check(req, bad, 0);
  endtask

  task automatic t_reset();
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 count_en", count_en, 1'b0);
  endtask

  task automatic t_reserved();
    wr(8'hFF);
    check("R2 reserved read zero", reg_rdata, 8'h1F);
    wr(8'hE0);
    check("R2 reserved-only write", reg_rdata, 8'h00);
    @(negedge clk);
    check("R2 no strobe", count_en, 1'b0);
  endtask

  task automatic t_selfclear();
    wr(8'h09);
    check("R3 flag set one cycle", reg_rdata, 8'h09);
    check("R3 no strobe during restart", count_en, 1'b0);
    @(negedge clk);
    check("R3 flag cleared", reg_rdata, 8'h01);
    check("R3 sys strobe resumes", count_en, 1'b1);
  endtask

  task automatic t_halt_hold();
    int seen = 0;
    wr(8'h1A);
    for (int i = 0; i < 100; i++) begin
      if (count_en) seen++;
      @(negedge clk);
    end
    check("R4 flag held", reg_rdata, 8'h1A);
    check("R4 no strobes div8", seen, 0);
    wr(8'h19);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (count_en) seen++;
      @(negedge clk);
    end
    check("R4 no strobes sys", seen, 0);
  endtask

  task automatic t_release_div(input logic [2:0] src, input int n);
    wr(8'h18 | 8'(src));
    repeat (3) @(negedge clk);
    wr(8'(src));
    check("R5 released", reg_rdata, 32'(src));
    run_div("R5/R7 divided strobe phase", n, 0, 3 * n);
  endtask

  task automatic t_off_sys();
    int seen = 0;
    wr(8'h00);
    for (int i = 0; i < 40; i++) begin
      if (count_en) seen++;
      @(negedge clk);
    end
    check("R6 off silent", seen, 0);
    wr(8'h01);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      if (count_en) seen++;
      @(negedge clk);
    end
    check("R6 sys every cycle", seen, 30);
  endtask

  task automatic t_switch_src();
    wr(8'h1A);
    wr(8'h02);
    for (int i = 0; i < 20; i++) @(negedge clk);
    // divider count is 20 here; write lands at next edge, count 21 after
    wr(8'h03);
    run_div("R9 switch keeps divider phase", 64, 21, 200);
  endtask

  task automatic pin_edge_check(input string req, input logic lvl, input logic exp_stb);
    ext_pin = lvl;
    @(negedge clk);
    check({req, " latency+1"}, count_en, 1'b0);
    @(negedge clk);
    check({req, " latency+2"}, count_en, exp_stb);
    @(negedge clk);
    check({req, " single"}, count_en, 1'b0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_pin();
    int seen = 0;
    ext_pin = 1'b0;
    wr(8'h07);
    repeat (4) @(negedge clk);
    pin_edge_check("R8 rise on rise", 1'b1, 1'b1);
    pin_edge_check("R8 fall ignored", 1'b0, 1'b0);
    wr(8'h06);
    repeat (4) @(negedge clk);
    pin_edge_check("R8 rise ignored", 1'b1, 1'b0);
    pin_edge_check("R8 fall on fall", 1'b0, 1'b1);
    wr(8'h07);
    for (int k = 0; k < 10; k++) begin
      ext_pin = 1'b1;
      repeat (4) begin @(negedge clk); if (count_en) seen++; end
      ext_pin = 1'b0;
      repeat (4) begin @(negedge clk); if (count_en) seen++; end
    end
    check("R8 one strobe per edge", seen, 10);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_selfclear();
    t_halt_hold();
    t_release_div(3'd2, 8);
    t_release_div(3'd3, 64);
    t_release_div(3'd4, 256);
    t_release_div(3'd5, 1024);
    t_off_sys();
    t_switch_src();
    t_pin();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule